// File: doc/BRIEF.md
# Output-Compare Timer with Forced Compare

This block is a 16-bit up-counter that advances on a timer tick and feeds three output-compare channels. Each channel holds a 16-bit compare value and a 2-bit pin-action field. The action decides what happens to the channel's waveform pin when the counter meets the compare value: hold, toggle, drive low or drive high. A match also raises the channel's flag, and software clears the flag by writing a one to it. With the clear-on-compare input high, channel A's compare value is the top of the count.

Software reaches the block over an 8-bit register bus. All 16-bit quantities (the counter and the three compare values) pass through one shared high-byte holding register, so both halves move together. A write-only strobe per channel forces the pin action at once, without a real match. The strobe works only when the PWM-mode input is low. It leaves the flags and the counter alone. Any counter write from software cancels compare matches on the next timer tick.

Top module: `ocmp_timer`

## Requirements
- R1: A synchronous reset sets the counter, every compare value, every pin-action field, every flag and every waveform pin to zero.
- R2: Writing a high-byte address (1 for the counter, 3+2i for compare i) loads the shared holding register only. Writing the matching low-byte address (0, or 2+2i) stores {holding, data} as one 16-bit value. Reading a low-byte address returns the low byte and copies that value's high byte into the holding register. Reading a high-byte address returns the holding register.
- R3: On a tick where the counter equals compare value i, flag i goes to 1 and pin i takes its action. The counter advances by one on every tick and wraps from 0xFFFF to 0x0000.
- R4: The action field of channel i sits at bits [2i+1:2i] of address 8. Code 00 holds the pin, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R5: With pwm_mode low, writing a one to bit i of address 9 applies channel i's action at that clock edge, using the field value in effect at that moment.
- R6: A forced compare never sets a flag and never changes the counter, including channel A in clear-on-compare mode.
- R7: With pwm_mode high, the force strobes leave the waveform pins unchanged.
- R8: Address 9 always reads as zero.
- R9: With ctc_mode high, a tick that matches channel A sends the counter to 0 instead of advancing it.
- R10: After a software write to the counter, the next tick produces no match on any channel, and clear-on-compare does not act on that tick. A tick in the same cycle as the write does not advance the counter.
- R11: Writing a one to bit i of address 10 clears flag i. A match in the same cycle wins, and the flag stays set.
- R12: Without a tick or a counter write, the counter holds its value.
- R13: A forced compare and a real match on the same channel in the same cycle apply the action once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer clock enable; one count per high cycle |
| pwm_mode | input | 1 | High selects a PWM mode, in which force strobes are ignored |
| ctc_mode | input | 1 | High selects clear-on-compare with channel A as top |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read enable |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_re is high |
| wave_out | output | 3 | Waveform pins, bit i for channel i |
| cmp_flag | output | 3 | Compare-match flags, bit i for channel i |

## Verification
Two functions can land in the same cycle. A force strobe can arrive on the very tick where the counter reaches the compare value, and a toggle action is where this shows: a double application would leave the pin unchanged. The bench sets this up by parking the counter one below the compare value and then raising the tick and the force-register write together. It judges the result by a single pin inversion and a flag that is set. A second overlap comes from a counter write followed by a tick that would otherwise match. In that case the pin and the flag must both stay put, and the counter must still advance.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

   typedef enum logic [1:0] {
      PIN_HOLD   = 2'b00,
      PIN_TOGGLE = 2'b01,
      PIN_LOW    = 2'b10,
      PIN_HIGH   = 2'b11
   } pin_act_e;

   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd0;
   localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd1;
   localparam logic [ADDR_W-1:0] A_CMP_BASE = 4'd2;
   localparam logic [ADDR_W-1:0] A_MODE     = 4'd8;
   localparam logic [ADDR_W-1:0] A_FORCE    = 4'd9;
   localparam logic [ADDR_W-1:0] A_FLAG     = 4'd10;

   function automatic logic apply_act(input pin_act_e act, input logic cur);
      case (act)
         PIN_TOGGLE: return ~cur;
         PIN_LOW:    return 1'b0;
         PIN_HIGH:   return 1'b1;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
   import ocmp_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16,
   parameter int NCH   = 3
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           bus_we,
   input  logic                           bus_re,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [BUS_W-1:0]               bus_wdata,
   output logic [BUS_W-1:0]               bus_rdata,
   input  logic [CNT_W-1:0]               cnt_q,
   input  logic [NCH-1:0]                 flag_q,
   output logic [NCH-1:0][CNT_W-1:0]      cmp_val,
   output logic [NCH-1:0][1:0]            mode_val,
   output logic [NCH-1:0]                 force_stb,
   output logic [NCH-1:0]                 flag_clr,
   output logic                           cnt_wr,
   output logic [CNT_W-1:0]               cnt_wr_val
);

   logic [BUS_W-1:0] hold_q;
   logic [NCH-1:0]   cmp_lo_sel;
   logic [NCH-1:0]   cmp_hi_sel;
   logic             hi_sel;

   always_comb begin
      for (int ch = 0; ch < NCH; ch++) begin
         cmp_lo_sel[ch] = (bus_addr == ADDR_W'(A_CMP_BASE + 2*ch));
         cmp_hi_sel[ch] = (bus_addr == ADDR_W'(A_CMP_BASE + 2*ch + 1));
      end
      hi_sel = (bus_addr == A_CNT_HI) || (|cmp_hi_sel);
   end

   assign cnt_wr     = bus_we && (bus_addr == A_CNT_LO);
   assign cnt_wr_val = {hold_q, bus_wdata};
   assign force_stb  = (bus_we && bus_addr == A_FORCE) ? bus_wdata[NCH-1:0] : '0;
   assign flag_clr   = (bus_we && bus_addr == A_FLAG)  ? bus_wdata[NCH-1:0] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q   <= '0;
         cmp_val  <= '0;
         mode_val <= '0;
      end else if (bus_we) begin
         if (hi_sel) hold_q <= bus_wdata;
         for (int ch = 0; ch < NCH; ch++)
            if (cmp_lo_sel[ch]) cmp_val[ch] <= {hold_q, bus_wdata};
         if (bus_addr == A_MODE) mode_val <= bus_wdata[2*NCH-1:0];
      end else if (bus_re) begin
         if (bus_addr == A_CNT_LO) hold_q <= cnt_q[CNT_W-1:BUS_W];
         for (int ch = 0; ch < NCH; ch++)
            if (cmp_lo_sel[ch]) hold_q <= cmp_val[ch][CNT_W-1:BUS_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         if (hi_sel)                     bus_rdata = hold_q;
         else if (bus_addr == A_CNT_LO)  bus_rdata = cnt_q[BUS_W-1:0];
         else if (bus_addr == A_MODE)    bus_rdata = BUS_W'(mode_val);
         else if (bus_addr == A_FLAG)    bus_rdata = BUS_W'(flag_q);
         for (int ch = 0; ch < NCH; ch++)
            if (cmp_lo_sel[ch]) bus_rdata = cmp_val[ch][BUS_W-1:0];
      end
   end

endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
   parameter int CNT_W  = 16,
   parameter bit CTC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             ctc_mode,
   input  logic             top_hit,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wr_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             cmp_en
);

   logic blk_q;
   logic clr_req;

   generate
      if (CTC_EN) begin : g_ctc
         assign clr_req = ctc_mode && top_hit;
      end else begin : g_free
         logic unused_ctc;
         assign unused_ctc = ctc_mode ^ top_hit;
         assign clr_req    = 1'b0;
      end
   endgenerate

   assign cmp_en = tick && !blk_q && !cnt_wr;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         blk_q <= 1'b0;
      end else if (cnt_wr) begin
         cnt_q <= cnt_wr_val;
         blk_q <= 1'b1;
      end else if (tick) begin
         blk_q <= 1'b0;
         cnt_q <= clr_req ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
   import ocmp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmp_en,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [1:0]       mode,
   input  logic             force_stb,
   input  logic             pwm_mode,
   input  logic             flag_clr,
   output logic             pin,
   output logic             flag,
   output logic             hit
);

   logic fire;

   assign hit  = cmp_en && (cnt_q == cmp_val);
   assign fire = hit || (force_stb && !pwm_mode);

   always_ff @(posedge clk) begin
      if (rst) begin
         pin  <= 1'b0;
         flag <= 1'b0;
      end else begin
         if (fire)          pin  <= apply_act(pin_act_e'(mode), pin);
         if (hit)           flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
   import ocmp_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int CNT_W  = 16,
   parameter int NCH    = 3,
   parameter bit CTC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              pwm_mode,
   input  logic              ctc_mode,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [NCH-1:0]    wave_out,
   output logic [NCH-1:0]    cmp_flag
);

   generate
      if (CNT_W != 2*BUS_W) begin : g_bad_width
         $error("ocmp_timer: CNT_W must be twice BUS_W");
      end
      if (NCH < 1 || NCH > 3) begin : g_bad_nch
         $error("ocmp_timer: NCH must lie between 1 and 3");
      end
      if (2*NCH > BUS_W) begin : g_bad_mode
         $error("ocmp_timer: action fields do not fit the bus");
      end
   endgenerate

   logic [CNT_W-1:0]          cnt_q;
   logic [CNT_W-1:0]          cnt_wr_val;
   logic                      cnt_wr;
   logic                      cmp_en;
   logic [NCH-1:0][CNT_W-1:0] cmp_val;
   logic [NCH-1:0][1:0]       mode_val;
   logic [NCH-1:0]            force_stb;
   logic [NCH-1:0]            flag_clr;
   logic [NCH-1:0]            ch_hit;

   ocmp_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W), .NCH(NCH)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .bus_we     (bus_we),
      .bus_re     (bus_re),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cnt_q      (cnt_q),
      .flag_q     (cmp_flag),
      .cmp_val    (cmp_val),
      .mode_val   (mode_val),
      .force_stb  (force_stb),
      .flag_clr   (flag_clr),
      .cnt_wr     (cnt_wr),
      .cnt_wr_val (cnt_wr_val)
   );

   ocmp_counter #(.CNT_W(CNT_W), .CTC_EN(CTC_EN)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .ctc_mode   (ctc_mode),
      .top_hit    (ch_hit[0]),
      .cnt_wr     (cnt_wr),
      .cnt_wr_val (cnt_wr_val),
      .cnt_q      (cnt_q),
      .cmp_en     (cmp_en)
   );

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         ocmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cmp_en    (cmp_en),
            .cnt_q     (cnt_q),
            .cmp_val   (cmp_val[ch]),
            .mode      (mode_val[ch]),
            .force_stb (force_stb[ch]),
            .pwm_mode  (pwm_mode),
            .flag_clr  (flag_clr[ch]),
            .pin       (wave_out[ch]),
            .flag      (cmp_flag[ch]),
            .hit       (ch_hit[ch])
         );
      end
   endgenerate

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
   parameter int CNT_W = 16,
   parameter int NCH   = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic             pwm_mode,
   input logic [CNT_W-1:0] cnt,
   input logic [NCH-1:0]   hit,
   input logic [NCH-1:0]   force_stb,
   input logic [NCH-1:0]   flag_clr,
   input logic             cnt_wr,
   input logic [NCH-1:0]   wave,
   input logic [NCH-1:0]   flag
);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (cnt == '0 && wave == '0 && flag == '0));

   // R7
   pwm_force_inert_chk: assert property (@(posedge clk) disable iff (rst)
      (pwm_mode && hit == '0) |=> $stable(wave));

   // R12
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!tick && !cnt_wr) |=> $stable(cnt));

   // R10
   write_blocks_match_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_wr |=> (hit == '0));

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_flag
         // R6
         flag_only_on_match_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flag[i]) |-> $past(hit[i]));
         // R11
         flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (flag_clr[i] && !hit[i]) |=> !flag[i]);
      end
   endgenerate

   logic unused_force;
   assign unused_force = ^force_stb;

endmodule

bind ocmp_timer ocmp_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick      (tick),
   .pwm_mode  (pwm_mode),
   .cnt       (cnt_q),
   .hit       (ch_hit),
   .force_stb (force_stb),
   .flag_clr  (flag_clr),
   .cnt_wr    (cnt_wr),
   .wave      (wave_out),
   .flag      (cmp_flag)
);

// File: tb/ocmp_timer_tb.sv
module ocmp_timer_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       pwm_mode = 1'b0;
   logic       ctc_mode = 1'b0;
   logic       bus_we = 1'b0;
   logic       bus_re = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [2:0] wave_out;
   logic [2:0] cmp_flag;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   ocmp_timer u_dut (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .pwm_mode  (pwm_mode),
      .ctc_mode  (ctc_mode),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wave_out  (wave_out),
      .cmp_flag  (cmp_flag)
   );

   always #5 clk = ~clk;

   // {action code[1:0], pin before, pin expected}
   localparam logic [3:0] VEC [0:7] = '{
      4'b00_0_0, 4'b00_1_1, 4'b01_0_1, 4'b01_1_0,
      4'b10_0_0, 4'b10_1_0, 4'b11_0_1, 4'b11_1_1
   };

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic wr16(input logic [3:0] lo_a, input logic [15:0] v);
      wr(lo_a + 4'd1, v[15:8]);
      wr(lo_a, v[7:0]);
   endtask

   task automatic rd16(input logic [3:0] lo_a, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(lo_a, lo);
      rd(lo_a + 4'd1, hi);
      v = {hi, lo};
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
      finish_run();
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  b;
      logic        p;

      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      check(wave_out == 3'b000, "R1 pins", 16'(wave_out), 16'h0);
      check(cmp_flag == 3'b000, "R1 flags", 16'(cmp_flag), 16'h0);
      rd16(4'd0, v); check(v == 16'h0, "R1 counter", v, 16'h0);
      rd16(4'd2, v); check(v == 16'h0, "R1 compare A", v, 16'h0);
      rd(4'd8, b);   check(b == 8'h0, "R1 action fields", 16'(b), 16'h0);

      // R4 R5 R6 action table via force strobe
      for (int i = 0; i < 8; i++) begin
         wr(4'd8, VEC[i][1] ? 8'b11 : 8'b10);
         wr(4'd9, 8'h01);
         wr(4'd8, {6'b0, VEC[i][3:2]});
         wr(4'd9, 8'h01);
         check(wave_out[0] == VEC[i][0], "R4 R5 forced action", 16'(wave_out[0]), 16'(VEC[i][0]));
         check(cmp_flag == 3'b000, "R6 force sets no flag", 16'(cmp_flag), 16'h0);
      end

      // R8 force register reads zero
      rd(4'd9, b); check(b == 8'h0, "R8 force reads zero", 16'(b), 16'h0);

      // R2 16-bit access through the holding register
      wr16(4'd0, 16'h1234);
      rd16(4'd0, v); check(v == 16'h1234, "R2 counter write/read", v, 16'h1234);
      wr(4'd1, 8'h56);
      rd16(4'd0, v); check(v == 16'h1234, "R2 high byte alone no commit", v, 16'h1234);
      wr16(4'd6, 16'hBEEF);
      rd16(4'd6, v); check(v == 16'hBEEF, "R2 compare C write/read", v, 16'hBEEF);

      // R12 hold without tick
      repeat (5) @(negedge clk);
      rd16(4'd0, v); check(v == 16'h1234, "R12 counter holds", v, 16'h1234);

      // R3 real match on channel B with drive-high action
      wr(4'd8, 8'b0000_1100);
      wr16(4'd4, 16'h0005);
      wr16(4'd0, 16'h0000);
      ticks(5);
      check(cmp_flag[1] == 1'b0, "R3 no flag before match", 16'(cmp_flag[1]), 16'h0);
      check(wave_out[1] == 1'b0, "R3 pin before match", 16'(wave_out[1]), 16'h0);
      ticks(1);
      check(cmp_flag[1] == 1'b1, "R3 flag on match", 16'(cmp_flag[1]), 16'h1);
      check(wave_out[1] == 1'b1, "R3 pin on match", 16'(wave_out[1]), 16'h1);
      rd16(4'd0, v); check(v == 16'h0006, "R3 counter advances", v, 16'h0006);

      // R11 write one to clear
      wr(4'd10, 8'h02);
      check(cmp_flag[1] == 1'b0, "R11 flag cleared", 16'(cmp_flag[1]), 16'h0);

      // R3 wrap
      wr16(4'd0, 16'hFFFF);
      ticks(1);
      rd16(4'd0, v); check(v == 16'h0000, "R3 wrap to zero", v, 16'h0000);

      // R7 PWM mode ignores force
      wr(4'd8, 8'b0000_0001);
      p = wave_out[0];
      pwm_mode = 1'b1;
      wr(4'd9, 8'h01);
      check(wave_out[0] == p, "R7 force ignored in PWM", 16'(wave_out[0]), 16'(p));
      pwm_mode = 1'b0;

      // R10 write blocks the next tick's match
      wr16(4'd2, 16'h0010);
      wr(4'd10, 8'h07);
      p = wave_out[0];
      wr16(4'd0, 16'h0010);
      ticks(1);
      check(cmp_flag[0] == 1'b0, "R10 blocked flag", 16'(cmp_flag[0]), 16'h0);
      check(wave_out[0] == p, "R10 blocked pin", 16'(wave_out[0]), 16'(p));
      rd16(4'd0, v); check(v == 16'h0011, "R10 counter still counts", v, 16'h0011);
      wr16(4'd0, 16'h000F);
      ticks(2);
      check(cmp_flag[0] == 1'b1, "R10 match after block", 16'(cmp_flag[0]), 16'h1);
      check(wave_out[0] == ~p, "R10 toggle after block", 16'(wave_out[0]), 16'(~p));

      // R13 force and real match in the same cycle toggle once
      wr(4'd10, 8'h01);
      wr16(4'd0, 16'h000F);
      ticks(1);
      p = wave_out[0];
      @(negedge clk);
      tick = 1'b1; bus_we = 1'b1; bus_addr = 4'd9; bus_wdata = 8'h01;
      @(negedge clk);
      tick = 1'b0; bus_we = 1'b0;
      check(wave_out[0] == ~p, "R13 single toggle", 16'(wave_out[0]), 16'(~p));
      check(cmp_flag[0] == 1'b1, "R13 flag from match", 16'(cmp_flag[0]), 16'h1);

      // R9 clear on compare with channel A top
      ctc_mode = 1'b1;
      wr(4'd8, 8'h00);
      wr16(4'd2, 16'h0003);
      wr16(4'd0, 16'h0000);
      ticks(4);
      rd16(4'd0, v); check(v == 16'h0000, "R9 cleared at top", v, 16'h0000);
      ticks(2);
      rd16(4'd0, v); check(v == 16'h0002, "R9 counts after clear", v, 16'h0002);

      // R6 force on A in clear-on-compare mode keeps counter and flag
      wr16(4'd0, 16'h0003);
      wr(4'd10, 8'h07);
      wr(4'd9, 8'h01);
      rd16(4'd0, v); check(v == 16'h0003, "R6 force no counter clear", v, 16'h0003);
      check(cmp_flag[0] == 1'b0, "R6 force no flag in CTC", 16'(cmp_flag[0]), 16'h0);
      ticks(1);
      rd16(4'd0, v); check(v == 16'h0004, "R10 blocked tick skips CTC clear", v, 16'h0004);
      ctc_mode = 1'b0;

      // R1 reset again clears everything
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check(wave_out == 3'b000 && cmp_flag == 3'b000, "R1 re-reset outputs",
            16'({wave_out, cmp_flag}), 16'h0);
      rd16(4'd2, v); check(v == 16'h0, "R1 compare A after reset", v, 16'h0);

      finish_run();
   end

endmodule